// File: doc/BRIEF.md
# Vector-to-Scalar Instruction Expander

This block sits behind instruction decode and turns one three-operand instruction (opcode, destination, two sources) into a run of plain scalar micro-instructions. A table holds one entry for each of the 32 architectural registers. Each entry has a vectorised/scalar flag, a length field and a 16-bit element mask. For every element, a vectorised operand's register number steps up by one and a scalar operand keeps its number. The opcode is copied unchanged onto every micro-instruction, so the block performs no arithmetic of its own.

The micro-instructions go into a small first-word-fall-through issue FIFO, which the execution side drains with a valid/ready pair. The front end presents instructions with a valid/ready pair. `in_ready` stays low while an expansion runs or while the FIFO is full. The table is loaded through a one-entry-per-cycle write port, and that port only takes effect while no expansion is running.

Top module: `vec_expander`

## Requirements
- R1: With the destination and both sources vectorised and the destination's length field set to 2, the instruction op r7 r4 r4 produces op r7 r4 r4, then op r8 r5 r5, then op r9 r6 r6.
- R2: A source whose flag is 0 (scalar) keeps its register number in every element. With r7 and r1 vectorised (r7 length field 2) and r4 scalar, op r7 r4 r1 produces op r7 r4 r1, then op r8 r4 r2, then op r9 r4 r3.
- R3: When any operand is vectorised, the element count is the destination entry's 4-bit length field plus one (range 1 to 16). Elements are generated in ascending order starting at element 0.
- R4: When all three operands are scalar, exactly one micro-instruction is produced, whatever the length field and mask hold.
- R5: Bit i of the destination entry's mask (bit 0 = element 0) set to 0 suppresses element i. The element index still advances, so later elements keep their register offsets.
- R6: If any stepped register number of an element would exceed 31, that element and every later one are dropped, the expansion ends, and `err` is high for exactly one cycle.
- R7: Every micro-instruction carries the input opcode unchanged.
- R8: `in_ready` is low while an expansion is in progress or the FIFO is full. No entry is written into a full FIFO; the expansion stalls instead.
- R9: A table write with `cfg_we` high has no effect while `busy` is high. A write in the same cycle as an instruction is accepted updates the table, but that instruction still sees the previous contents.
- R10: After reset, `busy` and `err` are low, `out_valid` is low, `in_ready` is high, and every table entry is scalar with length field 0 and mask all ones.
- R11: Micro-instructions leave the FIFO in the order they were generated, with no loss or duplication, under any pattern of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Register entry to write |
| cfg_vec | input | 1 | Vectorised flag to store |
| cfg_len | input | 4 | Length field to store (count minus one) |
| cfg_mask | input | 16 | Element mask to store |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 7 | Opcode |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| out_valid | output | 1 | FIFO head holds a micro-instruction |
| out_ready | input | 1 | Consumer takes the head |
| out_op | output | 7 | Micro-instruction opcode |
| out_rd | output | 5 | Micro-instruction destination |
| out_rs1 | output | 5 | Micro-instruction first source |
| out_rs2 | output | 5 | Micro-instruction second source |
| busy | output | 1 | Expansion in progress |
| err | output | 1 | One-cycle pulse: register range exceeded |

## Verification
Two events can land in the same cycle, and both are provoked on purpose. The first is a table write together with the acceptance of an instruction that reads the entry being written. The bench drives `cfg_we` and `in_valid` on the same edge and expects the old entry in that instruction's stream and the new entry in the next instruction's stream. The second is a FIFO push together with a pop while the FIFO is near full: `out_ready` is toggled pseudo-randomly, and at times is held low through a 16-element expansion, and every popped entry is compared against a queue-based model.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int REG_AW  = 5;
  localparam int NREG    = 1 << REG_AW;
  localparam int OP_W    = 7;
  localparam int LEN_W   = 4;
  localparam int MAX_LEN = 1 << LEN_W;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);

  // register number for element idx, one extra bit shows range overflow
  function automatic logic [REG_AW:0] step_reg(input logic [REG_AW-1:0] r,
                                               input logic vec,
                                               input logic [LEN_W-1:0] idx);
    logic [REG_AW:0] off;
    off = vec ? (REG_AW+1)'(idx) : '0;
    return (REG_AW+1)'(r) + off;
  endfunction
endpackage

// File: rtl/vx_cfg_table.sv
module vx_cfg_table
  import vx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic              wr_vec,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [MAX_LEN-1:0] wr_mask,
  input  logic [REG_AW-1:0] rd_a,
  input  logic [REG_AW-1:0] rd_b,
  input  logic [REG_AW-1:0] rd_c,
  output logic              vec_a,
  output logic              vec_b,
  output logic              vec_c,
  output logic [LEN_W-1:0]  len_a,
  output logic [MAX_LEN-1:0] mask_a
);
  logic [NREG-1:0]    vec_q;
  logic [LEN_W-1:0]   len_q  [NREG];
  logic [MAX_LEN-1:0] mask_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_q[g]  <= 1'b0;
        len_q[g]  <= '0;
        mask_q[g] <= '1;
      end else if (wr_en && wr_idx == REG_AW'(g)) begin
        vec_q[g]  <= wr_vec;
        len_q[g]  <= wr_len;
        mask_q[g] <= wr_mask;
      end
    end
  end

  assign vec_a  = vec_q[rd_a];
  assign vec_b  = vec_q[rd_b];
  assign vec_c  = vec_q[rd_c];
  assign len_a  = len_q[rd_a];
  assign mask_a = mask_q[rd_a];
endmodule

// File: rtl/vx_fifo.sv
module vx_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign valid   = (cnt != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/vx_sequencer.sv
module vx_sequencer
  import vx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  uop_t               in_uop,
  input  logic               vec_rd,
  input  logic               vec_rs1,
  input  logic               vec_rs2,
  input  logic [LEN_W-1:0]   len_rd,
  input  logic [MAX_LEN-1:0] mask_rd,
  input  logic               fifo_full,
  output logic               in_ready,
  output logic               accept_ev,
  output logic               push,
  output uop_t               push_uop,
  output logic               busy,
  output logic               err,
  output logic               go_ev,
  output logic               ovf_ev,
  output logic               done_ev
);
  uop_t               cur;
  logic               v_rd, v_s1, v_s2, all_sc;
  logic [MAX_LEN-1:0] msk;
  logic [LEN_W-1:0]   last, idx;
  logic [REG_AW:0]    s_rd, s_s1, s_s2;
  logic               range_bad;

  assign in_ready  = !busy && !fifo_full;
  assign accept_ev = in_valid && in_ready;

  assign s_rd = step_reg(cur.rd,  v_rd, idx);
  assign s_s1 = step_reg(cur.rs1, v_s1, idx);
  assign s_s2 = step_reg(cur.rs2, v_s2, idx);
  assign range_bad = s_rd[REG_AW] || s_s1[REG_AW] || s_s2[REG_AW];

  assign go_ev   = busy && !fifo_full;
  assign ovf_ev  = go_ev && range_bad;
  assign done_ev = go_ev && !range_bad && (idx == last);
  assign push    = go_ev && !range_bad && (all_sc || msk[idx]);

  always_comb begin
    push_uop.op  = cur.op;
    push_uop.rd  = s_rd[REG_AW-1:0];
    push_uop.rs1 = s_s1[REG_AW-1:0];
    push_uop.rs2 = s_s2[REG_AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      v_rd   <= 1'b0;
      v_s1   <= 1'b0;
      v_s2   <= 1'b0;
      all_sc <= 1'b1;
      msk    <= '1;
      last   <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= ovf_ev;
      if (accept_ev) begin
        cur    <= in_uop;
        v_rd   <= vec_rd;
        v_s1   <= vec_rs1;
        v_s2   <= vec_rs2;
        all_sc <= !(vec_rd || vec_rs1 || vec_rs2);
        last   <= (vec_rd || vec_rs1 || vec_rs2) ? len_rd : '0;
        msk    <= mask_rd;
        idx    <= '0;
        busy   <= 1'b1;
      end else if (ovf_ev || done_ev) begin
        busy <= 1'b0;
      end else if (go_ev) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_expander.sv
module vec_expander
  import vx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [REG_AW-1:0]   cfg_idx,
  input  logic                cfg_vec,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [MAX_LEN-1:0]  cfg_mask,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [REG_AW-1:0]   in_rd,
  input  logic [REG_AW-1:0]   in_rs1,
  input  logic [REG_AW-1:0]   in_rs2,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OP_W-1:0]     out_op,
  output logic [REG_AW-1:0]   out_rd,
  output logic [REG_AW-1:0]   out_rs1,
  output logic [REG_AW-1:0]   out_rs2,
  output logic                busy,
  output logic                err
);
  uop_t               in_u, push_u, head_u;
  logic               vec_rd, vec_rs1, vec_rs2;
  logic [LEN_W-1:0]   len_rd;
  logic [MAX_LEN-1:0] mask_rd;
  logic               fifo_full, push, cfg_fire;
  logic               accept_ev, go_ev, ovf_ev, done_ev;

  assign in_u.op  = in_op;
  assign in_u.rd  = in_rd;
  assign in_u.rs1 = in_rs1;
  assign in_u.rs2 = in_rs2;

  assign cfg_fire = cfg_we && !busy;

  vx_cfg_table u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_fire), .wr_idx(cfg_idx), .wr_vec(cfg_vec),
    .wr_len(cfg_len), .wr_mask(cfg_mask),
    .rd_a(in_rd), .rd_b(in_rs1), .rd_c(in_rs2),
    .vec_a(vec_rd), .vec_b(vec_rs1), .vec_c(vec_rs2),
    .len_a(len_rd), .mask_a(mask_rd)
  );

  vx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_uop(in_u),
    .vec_rd(vec_rd), .vec_rs1(vec_rs1), .vec_rs2(vec_rs2),
    .len_rd(len_rd), .mask_rd(mask_rd),
    .fifo_full(fifo_full),
    .in_ready(in_ready), .accept_ev(accept_ev),
    .push(push), .push_uop(push_u),
    .busy(busy), .err(err),
    .go_ev(go_ev), .ovf_ev(ovf_ev), .done_ev(done_ev)
  );

  vx_fifo #(.W(UOP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din(push_u),
    .pop(out_ready), .dout(head_u),
    .valid(out_valid), .full(fifo_full)
  );

  assign out_op  = head_u.op;
  assign out_rd  = head_u.rd;
  assign out_rs1 = head_u.rs1;
  assign out_rs2 = head_u.rs2;
endmodule

// File: rtl/vx_checker.sv
module vx_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic in_ready,
  input logic accept_ev,
  input logic push,
  input logic fifo_full,
  input logic err,
  input logic cfg_fire,
  input logic ovf_ev
);
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);

  p_ready_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_err_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> (err && !busy));

  p_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fire |-> !busy);

  p_accept_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> busy);
endmodule

bind vec_expander vx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .in_ready(in_ready),
  .accept_ev(accept_ev), .push(push), .fifo_full(fifo_full),
  .err(err), .cfg_fire(cfg_fire), .ovf_ev(ovf_ev)
);

// File: tb/tb_vec_expander.sv
module tb_vec_expander;
  import vx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_vec = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [3:0] cfg_len = '0;
  logic [15:0] cfg_mask = '0;
  logic in_valid = 1'b0;
  logic [6:0] in_op = '0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, busy, err;
  logic [6:0] out_op;
  logic [4:0] out_rd, out_rs1, out_rs2;

  always #10 clk = ~clk;  // 50 MHz

  vec_expander dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec),
    .cfg_len(cfg_len), .cfg_mask(cfg_mask),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .busy(busy), .err(err)
  );

  int compared = 0, mismatched = 0;
  int exp_err = 0, seen_err = 0;
  bit stall = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  bit        sh_vec [32];
  int        sh_len [32];
  bit [15:0] sh_mask[32];

  uop_t  exp_q[$];
  string tag_q[$];

  task automatic check(string req, bit ok, string what, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // behavioural model of the requirements
  task automatic model(int op, int rd, int s1, int s2, string req);
    bit anyv;
    int cnt;
    anyv = sh_vec[rd] || sh_vec[s1] || sh_vec[s2];
    cnt  = anyv ? sh_len[rd] + 1 : 1;
    for (int i = 0; i < cnt; i++) begin
      int a, b, c;
      uop_t u;
      a = rd + (sh_vec[rd] ? i : 0);
      b = s1 + (sh_vec[s1] ? i : 0);
      c = s2 + (sh_vec[s2] ? i : 0);
      if (a > 31 || b > 31 || c > 31) begin
        exp_err++;
        break;
      end
      if (!anyv || sh_mask[rd][i]) begin
        u.op = 7'(op); u.rd = 5'(a); u.rs1 = 5'(b); u.rs2 = 5'(c);
        exp_q.push_back(u);
        tag_q.push_back(req);
      end
    end
  endtask

  // consumer and stream comparison
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall ? 1'b0 : (lfsr[0] | lfsr[2]);
    if (err) seen_err++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R11", 1'b0, "unexpected micro-op rd", int'(out_rd), -1);
      end else begin
        uop_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_op == e.op, "op (R7)", int'(out_op), int'(e.op));
        check(t, out_rd == e.rd, "rd", int'(out_rd), int'(e.rd));
        check(t, out_rs1 == e.rs1, "rs1", int'(out_rs1), int'(e.rs1));
        check(t, out_rs2 == e.rs2, "rs2", int'(out_rs2), int'(e.rs2));
      end
    end
  end

  task automatic cfg(int idx, bit v, int len, bit [15:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_vec = v;
    cfg_len = 4'(len); cfg_mask = m;
    sh_vec[idx] = v; sh_len[idx] = len; sh_mask[idx] = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(int op, int rd, int s1, int s2, string req);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    model(op, rd, s1, s2, req);
    in_valid = 1'b1; in_op = 7'(op);
    in_rd = 5'(rd); in_rs1 = 5'(s1); in_rs2 = 5'(s2);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", busy && !in_ready, "busy/in_ready after accept",
          int'({busy, in_ready}), 2);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || busy) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check("R11", exp_q.size() == 0 && !out_valid, "leftover entries",
          exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) begin
      sh_vec[i] = 1'b0; sh_len[i] = 0; sh_mask[i] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", in_ready == 1'b1, "in_ready", int'(in_ready), 1);
    check("R10", busy == 1'b0, "busy", int'(busy), 0);
    check("R10", out_valid == 1'b0, "out_valid", int'(out_valid), 0);
    check("R10", err == 1'b0, "err", int'(err), 0);
    issue(7'h21, 3, 5, 9, "R10");   // reset tables: all scalar, one op
    drain();

    // R1: all vectorised
    cfg(7, 1, 2, 16'hFFFF);
    cfg(4, 1, 2, 16'hFFFF);
    issue(7'h33, 7, 4, 4, "R1");
    drain();

    // R2: scalar source stays fixed
    cfg(4, 0, 0, 16'hFFFF);
    cfg(1, 1, 0, 16'hFFFF);
    issue(7'h33, 7, 4, 1, "R2");
    drain();

    // R4: all scalar, length field ignored
    cfg(10, 0, 5, 16'h0000);
    issue(7'h13, 10, 11, 12, "R4");
    drain();

    // R3: count from destination length field
    cfg(15, 1, 4, 16'hFFFF);
    cfg(16, 1, 0, 16'hFFFF);
    issue(7'h05, 15, 16, 2, "R3");
    drain();
    // R3: destination scalar but a source vectorised, count from rd len
    cfg(12, 0, 3, 16'hFFFF);
    issue(7'h06, 12, 16, 2, "R3");
    drain();

    // R5: predicate mask, elements 0,2,5,7 of 8
    cfg(20, 1, 7, 16'h00A5);
    issue(7'h33, 20, 21, 22, "R5");
    drain();

    // R6: range overflow after r31
    cfg(28, 1, 7, 16'hFFFF);
    issue(7'h33, 28, 2, 3, "R6");
    drain();
    check("R6", seen_err == exp_err, "err pulses", seen_err, exp_err);
    check("R6", exp_err == 1, "model err count", exp_err, 1);

    // R7: different opcodes pass unchanged
    issue(7'h7F, 7, 4, 1, "R7");
    issue(7'h00, 7, 4, 1, "R7");
    drain();

    // R8 / R11: backpressure, 16 elements into a full FIFO
    cfg(0, 1, 15, 16'hFFFF);
    stall = 1'b1;
    issue(7'h01, 0, 0, 0, "R11");
    repeat (10) @(negedge clk);
    check("R8", out_valid && busy && !in_ready, "stalled with full FIFO",
          int'({out_valid, busy, in_ready}), 6);
    // R9: write while busy is ignored (r4 stays scalar, r7 keeps len 2)
    cfg_we = 1'b1; cfg_idx = 5'd7; cfg_vec = 1'b0; cfg_len = 4'd9; cfg_mask = 16'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    stall = 1'b0;
    drain();
    issue(7'h44, 7, 4, 1, "R9");
    drain();

    // R9: write in the same cycle as accept; instruction sees old entry
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    model(7'h55, 7, 4, 1, "R9");
    in_valid = 1'b1; in_op = 7'h55; in_rd = 5'd7; in_rs1 = 5'd4; in_rs2 = 5'd1;
    cfg_we = 1'b1; cfg_idx = 5'd7; cfg_vec = 1'b1; cfg_len = 4'd0; cfg_mask = 16'hFFFF;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    sh_vec[7] = 1'b1; sh_len[7] = 0; sh_mask[7] = 16'hFFFF;
    drain();
    issue(7'h56, 7, 4, 1, "R9");
    drain();

    // mixed traffic under random out_ready (R11)
    issue(7'h11, 20, 4, 1, "R11");
    issue(7'h12, 15, 16, 2, "R11");
    issue(7'h13, 28, 28, 1, "R11");
    issue(7'h14, 0, 4, 4, "R11");
    drain();
    check("R6", seen_err == exp_err, "err pulses total", seen_err, exp_err);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule